// File: doc/BRIEF.md
# Power-Gated Router Bypass Shell

This block wraps the four mesh ports of a router. It keeps traffic and flow control moving while the router's pipeline is switched off. When `gated` is low, the router is powered on. Every port then connects straight to the pipeline: arriving flits and credits go in, and the pipeline's flits and credits go out.

When `gated` is high, the pipeline is cut off. Each port turns into a one-entry register stage. A flit entering on one side is forwarded out of the opposite side on the next cycle, with its VC field untouched. A credit returned by the downstream neighbour is passed back toward the upstream neighbour in the same way. The two routers on either side of the sleeping one therefore act as direct neighbours for flow control.

On the cycle after the router falls asleep, the block tells each upstream neighbour to reload its counters from the pipeline's last known credit counts. On the cycle after it wakes, the block tells each upstream neighbour that every VC is fully available again. A router on a mesh edge bypasses only along the dimension in which it has neighbours on both sides. A corner router never bypasses.

Top module: `pg_bypass_shell`

## Requirements
- R1: After reset, every output (link, credit, notice and pipeline-side) is zero or invalid while `gated` is low and no traffic is offered.
- R2: With `gated` low, a flit or credit arriving on a side reaches the pipeline on that same side in the same cycle. The pipeline's outgoing flits and credits drive the link outputs of their own side in the same cycle.
- R3: With `gated` high, nothing is delivered to the pipeline, and pipeline flits or credits do not appear on any link output.
- R4: With `gated` high, a flit arriving on side s (N=0, E=1, S=2, W=3) leaves on side s^2 exactly one cycle later. A side with no new arrival shows no flit in that next cycle.
- R5: A bypassed flit leaves with its VC field (top two bits) and its payload (low DATA_W bits) unchanged.
- R6: With `gated` high, a credit arriving on side s leaves on credit output s^2 exactly one cycle later, with the same VC index.
- R7: In the cycle after `gated` is first seen high, each bypassing side s carries notice kind 1 (copy). Its count field holds the pipeline's counts for port s^2, with VC v at bits [3v+2:3v].
- R8: In the cycle after `gated` is first seen low, each bypassing side carries notice kind 2 (full). Every 3-bit VC count equals the buffer depth, 6.
- R9: An edge router bypasses flits and credits, and sends notices, only on the two sides of the dimension with neighbours on both sides. A corner router does none of these.
- R10: A notice lasts one cycle. While `gated` holds its value, the notice kind is 0 on every side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gated | input | 1 | 1 while the router pipeline is switched off |
| link_in_vld | input | 4 | Flit valid arriving on each side |
| link_in_flit | input | 4x34 | Arriving flit per side: VC in top 2 bits, payload below |
| link_out_vld | output | 4 | Flit valid leaving on each side |
| link_out_flit | output | 4x34 | Leaving flit per side |
| cred_in_vld | input | 4 | Credit returned by the neighbour on each side |
| cred_in_vc | input | 4x2 | VC of the returned credit |
| cred_out_vld | output | 4 | Credit sent to the neighbour on each side |
| cred_out_vc | output | 4x2 | VC of the sent credit |
| note_kind | output | 4x2 | Per-side notice: 0 none, 1 copy, 2 full |
| note_cnt | output | 4x12 | Per-side credit counts carried by a notice, 3 bits per VC |
| pipe_in_vld | output | 4 | Flit valid toward the pipeline |
| pipe_in_flit | output | 4x34 | Flit toward the pipeline |
| pipe_out_vld | input | 4 | Pipeline flit valid per output side |
| pipe_out_flit | input | 4x34 | Pipeline flit per output side |
| pipe_cred_in_vld | output | 4 | Credit valid toward the pipeline |
| pipe_cred_in_vc | output | 4x2 | VC of the credit toward the pipeline |
| pipe_cred_out_vld | input | 4 | Pipeline credit valid per side |
| pipe_cred_out_vc | input | 4x2 | VC of the pipeline credit |
| pipe_cred_cnt | input | 4x12 | Pipeline's downstream credit counts per output port |

## Verification
A stale or lost hold register shows up on the opposite side's link or credit output in the very next cycle: a missing item, a duplicated item, or one with a changed VC. A wrong sleep-edge register shows up as a notice that is missing, repeated or mistimed in the cycle right after `gated` changes. A wrong side mask shows up at once as traffic or notices on a side that an edge or corner router must keep silent. For these reasons the bench compares every output one cycle after each stimulus.

// File: rtl/bypass_pkg.sv
package bypass_pkg;

    localparam int NDIR = 4;

    typedef enum logic [1:0] {
        NOTE_NONE = 2'd0,
        NOTE_COPY = 2'd1,
        NOTE_FULL = 2'd2
    } note_e;

    // Side numbering: N=0, E=1, S=2, W=3; the facing side is two steps on.
    function automatic int opposite(input int s);
        return (s + 2) % NDIR;
    endfunction

    // Bit per side: 1 when that side takes part in bypass at this mesh position.
    function automatic logic [NDIR-1:0] bypass_mask(input int col, input int row,
                                                    input int cols, input int rows);
        logic vert, horz;
        vert = (row > 0) && (row < rows - 1);
        horz = (col > 0) && (col < cols - 1);
        return {horz, vert, horz, vert};
    endfunction

endpackage

// File: rtl/relay_stage.sv
module relay_stage #(
    parameter int W  = 8,
    parameter bit EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         gated,
    input  logic         in_vld,
    input  logic [W-1:0] in_data,
    input  logic         pipe_vld,
    input  logic [W-1:0] pipe_data,
    output logic         out_vld,
    output logic [W-1:0] out_data
);

    logic         hold_vld;
    logic [W-1:0] hold_data;

    generate
        if (EN) begin : g_live
            always_ff @(posedge clk) begin
                if (rst) begin
                    hold_vld  <= 1'b0;
                    hold_data <= '0;
                end else begin
                    hold_vld  <= gated & in_vld;
                    hold_data <= (gated & in_vld) ? in_data : '0;
                end
            end

            a_r4_r6_next_cycle: assert property (@(posedge clk) disable iff (rst)
                (gated && in_vld) |=> out_vld);
            a_r5_r6_field_kept: assert property (@(posedge clk) disable iff (rst)
                (gated && in_vld) |=> (out_data == $past(in_data)));
        end else begin : g_dead
            logic unused_in;
            assign unused_in = ^{in_vld, in_data, clk, rst};
            assign hold_vld  = 1'b0;
            assign hold_data = '0;
        end
    endgenerate

    // A held item always drains first, even if the gate has just opened.
    always_comb begin
        if (hold_vld) begin
            out_vld  = 1'b1;
            out_data = hold_data;
        end else if (!gated) begin
            out_vld  = pipe_vld;
            out_data = pipe_data;
        end else begin
            out_vld  = 1'b0;
            out_data = '0;
        end
    end

endmodule

// File: rtl/gate_notifier.sv
module gate_notifier
    import bypass_pkg::*;
#(
    parameter int              NUM_VC = 4,
    parameter int              CNT_W  = 3,
    parameter int              DEPTH  = 6,
    parameter logic [NDIR-1:0] MASK   = '1,
    localparam int             CW     = NUM_VC * CNT_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     gated,
    input  logic [NDIR-1:0][CW-1:0]  cnt_in,
    output logic [NDIR-1:0][1:0]     kind,
    output logic [NDIR-1:0][CW-1:0]  cnt_out
);

    localparam logic [CW-1:0] FULL_VEC = {NUM_VC{CNT_W'(DEPTH)}};

    logic gated_q;
    logic rise, fall;

    always_ff @(posedge clk) begin
        gated_q <= gated;
    end

    assign rise = gated & ~gated_q;
    assign fall = ~gated & gated_q;

    logic unused_cnt;
    assign unused_cnt = ^cnt_in;

    for (genvar s = 0; s < NDIR; s++) begin : g_side
        localparam int OPP = opposite(s);
        if (MASK[s]) begin : g_on
            always_ff @(posedge clk) begin
                if (rst) begin
                    kind[s]    <= NOTE_NONE;
                    cnt_out[s] <= '0;
                end else if (rise) begin
                    kind[s]    <= NOTE_COPY;
                    cnt_out[s] <= cnt_in[OPP];
                end else if (fall) begin
                    kind[s]    <= NOTE_FULL;
                    cnt_out[s] <= FULL_VEC;
                end else begin
                    kind[s]    <= NOTE_NONE;
                    cnt_out[s] <= '0;
                end
            end

            a_r7_copy_on_sleep: assert property (@(posedge clk) disable iff (rst)
                $rose(gated) |=> (kind[s] == NOTE_COPY && cnt_out[s] == $past(cnt_in[OPP])));
            a_r8_full_on_wake: assert property (@(posedge clk) disable iff (rst)
                $fell(gated) |=> (kind[s] == NOTE_FULL && cnt_out[s] == FULL_VEC));
            a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
                $stable(gated) |=> (kind[s] == NOTE_NONE));
        end else begin : g_off
            assign kind[s]    = NOTE_NONE;
            assign cnt_out[s] = '0;
        end
    end

endmodule

// File: rtl/pg_bypass_shell.sv
module pg_bypass_shell
    import bypass_pkg::*;
#(
    parameter int  DATA_W    = 32,
    parameter int  NUM_VC    = 4,
    parameter int  BUF_DEPTH = 6,
    parameter int  MESH_COLS = 4,
    parameter int  MESH_ROWS = 4,
    parameter int  MY_COL    = 1,
    parameter int  MY_ROW    = 1,
    localparam int VC_W      = $clog2(NUM_VC),
    localparam int FLIT_W    = VC_W + DATA_W,
    localparam int CNT_W     = $clog2(BUF_DEPTH + 1),
    localparam int CV_W      = NUM_VC * CNT_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         gated,
    input  logic [NDIR-1:0]              link_in_vld,
    input  logic [NDIR-1:0][FLIT_W-1:0]  link_in_flit,
    output logic [NDIR-1:0]              link_out_vld,
    output logic [NDIR-1:0][FLIT_W-1:0]  link_out_flit,
    input  logic [NDIR-1:0]              cred_in_vld,
    input  logic [NDIR-1:0][VC_W-1:0]    cred_in_vc,
    output logic [NDIR-1:0]              cred_out_vld,
    output logic [NDIR-1:0][VC_W-1:0]    cred_out_vc,
    output logic [NDIR-1:0][1:0]         note_kind,
    output logic [NDIR-1:0][CV_W-1:0]    note_cnt,
    output logic [NDIR-1:0]              pipe_in_vld,
    output logic [NDIR-1:0][FLIT_W-1:0]  pipe_in_flit,
    input  logic [NDIR-1:0]              pipe_out_vld,
    input  logic [NDIR-1:0][FLIT_W-1:0]  pipe_out_flit,
    output logic [NDIR-1:0]              pipe_cred_in_vld,
    output logic [NDIR-1:0][VC_W-1:0]    pipe_cred_in_vc,
    input  logic [NDIR-1:0]              pipe_cred_out_vld,
    input  logic [NDIR-1:0][VC_W-1:0]    pipe_cred_out_vc,
    input  logic [NDIR-1:0][CV_W-1:0]    pipe_cred_cnt
);

    localparam logic [NDIR-1:0] MASK = bypass_mask(MY_COL, MY_ROW, MESH_COLS, MESH_ROWS);

    // Input demux: the pipeline sees arrivals only while powered.
    for (genvar s = 0; s < NDIR; s++) begin : g_demux
        assign pipe_in_vld[s]      = link_in_vld[s] & ~gated;
        assign pipe_in_flit[s]     = gated ? '0 : link_in_flit[s];
        assign pipe_cred_in_vld[s] = cred_in_vld[s] & ~gated;
        assign pipe_cred_in_vc[s]  = gated ? '0 : cred_in_vc[s];
    end

    // Output side o is fed from the facing side while gated.
    for (genvar o = 0; o < NDIR; o++) begin : g_out
        localparam int OPP = opposite(o);

        relay_stage #(.W(FLIT_W), .EN(MASK[o])) u_flit (
            .clk       (clk),
            .rst       (rst),
            .gated     (gated),
            .in_vld    (link_in_vld[OPP]),
            .in_data   (link_in_flit[OPP]),
            .pipe_vld  (pipe_out_vld[o]),
            .pipe_data (pipe_out_flit[o]),
            .out_vld   (link_out_vld[o]),
            .out_data  (link_out_flit[o])
        );

        relay_stage #(.W(VC_W), .EN(MASK[o])) u_cred (
            .clk       (clk),
            .rst       (rst),
            .gated     (gated),
            .in_vld    (cred_in_vld[OPP]),
            .in_data   (cred_in_vc[OPP]),
            .pipe_vld  (pipe_cred_out_vld[o]),
            .pipe_data (pipe_cred_out_vc[o]),
            .out_vld   (cred_out_vld[o]),
            .out_data  (cred_out_vc[o])
        );
    end

    gate_notifier #(
        .NUM_VC (NUM_VC),
        .CNT_W  (CNT_W),
        .DEPTH  (BUF_DEPTH),
        .MASK   (MASK)
    ) u_note (
        .clk     (clk),
        .rst     (rst),
        .gated   (gated),
        .cnt_in  (pipe_cred_cnt),
        .kind    (note_kind),
        .cnt_out (note_cnt)
    );

    // R3: a side with nothing arriving opposite stays silent the next gated cycle.
    for (genvar o = 0; o < NDIR; o++) begin : g_chk
        localparam int OPP = opposite(o);
        a_r3_gated_quiet: assert property (@(posedge clk) disable iff (rst)
            (gated && !link_in_vld[OPP]) ##1 gated |-> !link_out_vld[o]);
    end

endmodule

// File: tb/pg_bypass_shell_test.sv
`timescale 1ns/1ps
module pg_bypass_shell_test;

    localparam int DW  = 32;
    localparam int FW  = 34;
    localparam int CVW = 12;

    logic clk = 1'b0;
    logic rst;
    logic gated;
    logic [3:0]         li_vld;
    logic [3:0][FW-1:0] li_flit;
    logic [3:0]         ci_vld;
    logic [3:0][1:0]    ci_vc;
    logic [3:0]         po_vld;
    logic [3:0][FW-1:0] po_flit;
    logic [3:0]         pco_vld;
    logic [3:0][1:0]    pco_vc;
    logic [3:0][CVW-1:0] pcnt;

    logic [3:0]          lo_vld  [3];
    logic [3:0][FW-1:0]  lo_flit [3];
    logic [3:0]          co_vld  [3];
    logic [3:0][1:0]     co_vc   [3];
    logic [3:0][1:0]     nk      [3];
    logic [3:0][CVW-1:0] nc      [3];
    logic [3:0]          pi_vld  [3];
    logic [3:0][FW-1:0]  pi_flit [3];
    logic [3:0]          pci_vld [3];
    logic [3:0][1:0]     pci_vc  [3];

    always #2 clk = ~clk;

    pg_bypass_shell #(.MY_COL(1), .MY_ROW(1)) uut (
        .clk(clk), .rst(rst), .gated(gated),
        .link_in_vld(li_vld), .link_in_flit(li_flit),
        .link_out_vld(lo_vld[0]), .link_out_flit(lo_flit[0]),
        .cred_in_vld(ci_vld), .cred_in_vc(ci_vc),
        .cred_out_vld(co_vld[0]), .cred_out_vc(co_vc[0]),
        .note_kind(nk[0]), .note_cnt(nc[0]),
        .pipe_in_vld(pi_vld[0]), .pipe_in_flit(pi_flit[0]),
        .pipe_out_vld(po_vld), .pipe_out_flit(po_flit),
        .pipe_cred_in_vld(pci_vld[0]), .pipe_cred_in_vc(pci_vc[0]),
        .pipe_cred_out_vld(pco_vld), .pipe_cred_out_vc(pco_vc),
        .pipe_cred_cnt(pcnt));

    pg_bypass_shell #(.MY_COL(0), .MY_ROW(1)) uut_edge (
        .clk(clk), .rst(rst), .gated(gated),
        .link_in_vld(li_vld), .link_in_flit(li_flit),
        .link_out_vld(lo_vld[1]), .link_out_flit(lo_flit[1]),
        .cred_in_vld(ci_vld), .cred_in_vc(ci_vc),
        .cred_out_vld(co_vld[1]), .cred_out_vc(co_vc[1]),
        .note_kind(nk[1]), .note_cnt(nc[1]),
        .pipe_in_vld(pi_vld[1]), .pipe_in_flit(pi_flit[1]),
        .pipe_out_vld(po_vld), .pipe_out_flit(po_flit),
        .pipe_cred_in_vld(pci_vld[1]), .pipe_cred_in_vc(pci_vc[1]),
        .pipe_cred_out_vld(pco_vld), .pipe_cred_out_vc(pco_vc),
        .pipe_cred_cnt(pcnt));

    pg_bypass_shell #(.MY_COL(0), .MY_ROW(0)) uut_corner (
        .clk(clk), .rst(rst), .gated(gated),
        .link_in_vld(li_vld), .link_in_flit(li_flit),
        .link_out_vld(lo_vld[2]), .link_out_flit(lo_flit[2]),
        .cred_in_vld(ci_vld), .cred_in_vc(ci_vc),
        .cred_out_vld(co_vld[2]), .cred_out_vc(co_vc[2]),
        .note_kind(nk[2]), .note_cnt(nc[2]),
        .pipe_in_vld(pi_vld[2]), .pipe_in_flit(pi_flit[2]),
        .pipe_out_vld(po_vld), .pipe_out_flit(po_flit),
        .pipe_cred_in_vld(pci_vld[2]), .pipe_cred_in_vc(pci_vc[2]),
        .pipe_cred_out_vld(pco_vld), .pipe_cred_out_vc(pco_vc),
        .pipe_cred_cnt(pcnt));

    // Port codes for the scoreboard: 0 link out, 1 credit out, 2 notice,
    // 3 flit to pipeline, 4 credit to pipeline. Instances: 0 interior, 1 edge, 2 corner.
    typedef struct {
        int          cyc;
        int          inst;
        int          port;
        int          side;
        logic [63:0] val;
        string       req;
    } exp_t;

    exp_t q[$];
    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;

    function automatic logic [63:0] act(input int inst, input int port, input int side);
        case (port)
            0: return 64'({lo_vld[inst][side], lo_flit[inst][side]});
            1: return 64'({co_vld[inst][side], co_vc[inst][side]});
            2: return 64'({nk[inst][side], nc[inst][side]});
            3: return 64'({pi_vld[inst][side], pi_flit[inst][side]});
            default: return 64'({pci_vld[inst][side], pci_vc[inst][side]});
        endcase
    endfunction

    function automatic logic [FW-1:0] mk_flit(input logic [1:0] vc, input logic [DW-1:0] d);
        return {vc, d};
    endfunction

    function automatic logic [CVW-1:0] cvec(input int p, input int seed);
        logic [CVW-1:0] r;
        for (int v = 0; v < 4; v++) r[v*3 +: 3] = 3'((p * 2 + v + seed) % 7);
        return r;
    endfunction

    localparam logic [CVW-1:0] FULLV = {4{3'd6}};

    task automatic expect_it(input int inst, input int port, input int side,
                             input logic [63:0] v, input string r);
        q.push_back('{cyc + 1, inst, port, side, v, r});
    endtask

    task automatic idle();
        li_vld = '0;  li_flit = '0;
        ci_vld = '0;  ci_vc = '0;
        po_vld = '0;  po_flit = '0;
        pco_vld = '0; pco_vc = '0;
    endtask

    task automatic set_counts(input int seed);
        for (int p = 0; p < 4; p++) pcnt[p] = cvec(p, seed);
    endtask

    // Monitor: compares every item due this cycle, just after the edge.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            #1;
            for (int i = q.size() - 1; i >= 0; i--) begin
                if (q[i].cyc == cyc) begin
                    logic [63:0] a;
                    a = act(q[i].inst, q[i].port, q[i].side);
                    n_cmp++;
                    if (a !== q[i].val) begin
                        n_bad++;
                        $display("FAIL %s: inst %0d port %0d side %0d actual %h expected %h",
                                 q[i].req, q[i].inst, q[i].port, q[i].side, a, q[i].val);
                    end
                    q.delete(i);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        gated = 1'b0;
        idle();
        set_counts(0);
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1: idle outputs on every instance, port and side
        @(negedge clk);
        for (int i = 0; i < 3; i++)
            for (int p = 0; p < 5; p++)
                for (int s = 0; s < 4; s++)
                    expect_it(i, p, s, 64'd0, "R1");

        // R2: powered pass-through in both directions
        @(negedge clk);
        idle();
        li_vld[1] = 1'b1; li_flit[1] = mk_flit(2'd1, 32'hA1A1_0001);
        po_vld[3] = 1'b1; po_flit[3] = mk_flit(2'd2, 32'hB2B2_0002);
        ci_vld[0] = 1'b1; ci_vc[0] = 2'd2;
        pco_vld[2] = 1'b1; pco_vc[2] = 2'd3;
        expect_it(0, 3, 1, 64'({1'b1, mk_flit(2'd1, 32'hA1A1_0001)}), "R2");
        expect_it(0, 0, 3, 64'({1'b1, mk_flit(2'd2, 32'hB2B2_0002)}), "R2");
        expect_it(0, 0, 1, 64'd0, "R2");
        expect_it(0, 4, 0, 64'({1'b1, 2'd2}), "R2");
        expect_it(0, 1, 2, 64'({1'b1, 2'd3}), "R2");

        // Sleep entry: R7 copy notices, R3 pipeline isolated, R9 edge/corner sides
        @(negedge clk);
        idle();
        set_counts(1);
        gated = 1'b1;
        po_vld[0] = 1'b1; po_flit[0] = mk_flit(2'd3, 32'h1234_5678);
        for (int s = 0; s < 4; s++) begin
            expect_it(0, 2, s, 64'({2'd1, cvec(s ^ 2, 1)}), "R7");
            expect_it(1, 2, s, (s % 2 == 0) ? 64'({2'd1, cvec(s ^ 2, 1)}) : 64'd0, "R9");
            expect_it(2, 2, s, 64'd0, "R9");
        end
        expect_it(0, 0, 0, 64'd0, "R3");

        // R4/R5: all four sides at once; R6 credit relay; R10 notices cleared
        @(negedge clk);
        idle();
        for (int s = 0; s < 4; s++) begin
            li_vld[s] = 1'b1;
            li_flit[s] = mk_flit(2'(s), 32'hC0DE_0000 + DW'(s));
        end
        ci_vld[3] = 1'b1; ci_vc[3] = 2'd1;
        pco_vld[0] = 1'b1; pco_vc[0] = 2'd2;
        for (int s = 0; s < 4; s++) begin
            expect_it(0, 0, s ^ 2, 64'({1'b1, mk_flit(2'(s), 32'hC0DE_0000 + DW'(s))}), "R4 R5");
            expect_it(0, 3, s, 64'd0, "R3");
            expect_it(0, 2, s, 64'd0, "R10");
            expect_it(2, 0, s, 64'd0, "R9");
        end
        expect_it(0, 1, 1, 64'({1'b1, 2'd1}), "R6");
        expect_it(0, 1, 0, 64'd0, "R3");
        expect_it(1, 0, 0, 64'({1'b1, mk_flit(2'd2, 32'hC0DE_0002)}), "R9");
        expect_it(1, 0, 2, 64'({1'b1, mk_flit(2'd0, 32'hC0DE_0000)}), "R9");
        expect_it(1, 0, 1, 64'd0, "R9");
        expect_it(1, 0, 3, 64'd0, "R9");
        expect_it(1, 1, 1, 64'd0, "R9");

        // R4: back-to-back, one side only; the others drain to empty
        @(negedge clk);
        idle();
        li_vld[3] = 1'b1; li_flit[3] = mk_flit(2'd3, 32'hDEAD_BEEF);
        ci_vld[2] = 1'b1; ci_vc[2] = 2'd0;
        expect_it(0, 0, 1, 64'({1'b1, mk_flit(2'd3, 32'hDEAD_BEEF)}), "R4 R5");
        expect_it(0, 0, 3, 64'd0, "R4");
        expect_it(0, 0, 0, 64'd0, "R4");
        expect_it(0, 1, 0, 64'({1'b1, 2'd0}), "R6");
        expect_it(0, 1, 1, 64'd0, "R6");

        // Wake: R8 full notices, R9 edge sides, R2 demux back to pipeline
        @(negedge clk);
        idle();
        gated = 1'b0;
        li_vld[0] = 1'b1; li_flit[0] = mk_flit(2'd1, 32'h0F0F_0F0F);
        for (int s = 0; s < 4; s++) begin
            expect_it(0, 2, s, 64'({2'd2, FULLV}), "R8");
            expect_it(1, 2, s, (s % 2 == 0) ? 64'({2'd2, FULLV}) : 64'd0, "R9");
            expect_it(2, 2, s, 64'd0, "R9");
        end
        expect_it(0, 3, 0, 64'({1'b1, mk_flit(2'd1, 32'h0F0F_0F0F)}), "R2");
        expect_it(0, 0, 2, 64'd0, "R2");

        // R10: powered and steady, no notice
        @(negedge clk);
        idle();
        for (int s = 0; s < 4; s++) expect_it(0, 2, s, 64'd0, "R10");

        // Second sleep with fresh counts: R7 re-arms
        @(negedge clk);
        idle();
        set_counts(4);
        gated = 1'b1;
        for (int s = 0; s < 4; s++) expect_it(0, 2, s, 64'({2'd1, cvec(s ^ 2, 4)}), "R7");

        // R4/R6 again on the vertical pair
        @(negedge clk);
        idle();
        li_vld[0] = 1'b1; li_flit[0] = mk_flit(2'd2, 32'h5555_AAAA);
        ci_vld[1] = 1'b1; ci_vc[1] = 2'd3;
        expect_it(0, 0, 2, 64'({1'b1, mk_flit(2'd2, 32'h5555_AAAA)}), "R4 R5");
        expect_it(0, 1, 3, 64'({1'b1, 2'd3}), "R6");
        expect_it(1, 0, 2, 64'({1'b1, mk_flit(2'd2, 32'h5555_AAAA)}), "R9");
        expect_it(1, 1, 3, 64'd0, "R9");
        expect_it(0, 2, 0, 64'd0, "R10");

        @(negedge clk);
        idle();
        gated = 1'b0;
        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: actual %0d items left expected 0", q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule